// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block connects a simple synchronous request port to an external asynchronous static RAM of 64K words by 16 bits. A requester presents a command with a write flag, a word address, write data and one active-high strobe per byte lane. The controller accepts it while `req_ready` is high. It then runs the active-low pin protocol of the RAM: chip select, write strobe, output enable and one enable per byte lane. The 16-bit data bus is split into a driven value, a drive enable and a separate input.

Each transaction runs through four phases. In the idle phase the RAM is deselected. The setup phase presents the address and the lane enables. The access phase holds the strobe for a number of clock cycles derived from the clock period and the RAM access time. The hold phase releases the strobe while the address stays put. Read data is captured at the last access cycle and returned with a one-cycle `rsp_valid` pulse. The controller drives the bus only for writes, so there is always a released cycle before output enable is asserted for a read. A request whose strobes are both clear finishes without any strobe on the pins.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While idle (`req_ready` high, and after reset), chip enable, write enable, output enable and both lane enables are all high (inactive), and `ram_dq_oe` is low.
- R2: During an accepted transaction, `ram_addr` equals the request address, and lane enable bit k is low exactly when request strobe bit k was set (bit 0 = bits 7:0, bit 1 = bits 15:8). Both stay constant from setup through hold.
- R3: For a write, write enable is low for exactly the access cycles. The cycle before them (setup) and the cycle after them (hold) have chip enable low and write enable high. Output enable stays high for the whole write.
- R4: `ram_dq_oe` is high from setup through hold of a write and never during a read or in idle. While it is high, `ram_dq_out` equals the request write data.
- R5: For a read, output enable is low for exactly the access cycles, and write enable stays high.
- R6: A read gives one `rsp_valid` pulse in the hold cycle. `rsp_rdata` lane k holds the `ram_dq_in` bits sampled at the last access cycle if strobe k was set, and zero otherwise.
- R7: A request with both strobes clear leaves every RAM pin inactive and keeps `req_ready` high. If it is a read, `rsp_valid` pulses the next cycle with `rsp_rdata` zero. If it is a write, memory contents are unchanged.
- R8: Output enable is never low while `ram_dq_oe` is high, and `ram_dq_oe` was low in the cycle before any cycle in which output enable is low.
- R9: After an enabled request is accepted, `req_ready` is low for exactly the setup, access and hold cycles (wait count plus two), then high again.
- R10: The access phase lasts max(1, ceil(ACC_PS / CLK_PS)) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | LANES | Active-high byte-lane strobes |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_lane_n | output | LANES | RAM byte-lane enables, active low |
| ram_dq_out | output | DATA_W | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Controller drives the data bus |
| ram_dq_in | input | DATA_W | Value read from the data bus |

## Verification
A wrong sequencer state shows up on the pins within the same cycle. A strobe that is asserted early or late, a lane enable that does not match the strobes, or a `req_ready` that returns too soon all differ from the bench's phase-by-phase model at the next falling edge. A wrong wait counter changes the length of the write-enable or output-enable pulse. Because of this, the first transaction after reset already shows it. A wrong lane mask or capture point only becomes visible one cycle later, in the read response. The bench's RAM model drives filler values on unselected lanes, so a lane that leaks through shows up as a data mismatch.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2,
      ST_HOLD   = 2'd3
   } seq_state_e;

   // Number of access cycles: ceiling of access time over clock period, at least one.
   function automatic int unsigned access_cycles(input int unsigned clk_ps,
                                                 input int unsigned acc_ps);
      int unsigned n;
      n = (acc_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int unsigned WAIT_CYC = 1,
   parameter int unsigned CNT_W    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic last
);
   generate
      if (WAIT_CYC == 1) begin : g_single
         // One access cycle: no counter needed.
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, clear};
         assign last = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
         assign last = run && (cnt_q == CNT_W'(WAIT_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   input  logic              acc_last,
   output logic              req_ready,
   output seq_state_e        state_q,
   output seq_state_e        state_d,
   output logic              txn_write_q,
   output logic              txn_write_d,
   output logic [LANES-1:0]  txn_be_q,
   output logic [LANES-1:0]  txn_be_d,
   output logic [ADDR_W-1:0] txn_addr_q,
   output logic [DATA_W-1:0] txn_wdata_q,
   output logic              timer_clear,
   output logic              timer_run,
   output logic              cap_en,
   output logic [LANES-1:0]  cap_be
);
   logic accept;
   logic any_lane;
   logic load;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign any_lane  = |req_be;
   assign load      = accept && any_lane;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (load) state_d = ST_SETUP;
         ST_SETUP:  state_d = ST_ACCESS;
         ST_ACCESS: if (acc_last) state_d = ST_HOLD;
         ST_HOLD:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign txn_write_d = load ? req_write : txn_write_q;
   assign txn_be_d    = load ? req_be    : txn_be_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         txn_write_q <= 1'b0;
         txn_be_q    <= '0;
         txn_addr_q  <= '0;
         txn_wdata_q <= '0;
      end else begin
         state_q     <= state_d;
         txn_write_q <= txn_write_d;
         txn_be_q    <= txn_be_d;
         if (load) begin
            txn_addr_q  <= req_addr;
            txn_wdata_q <= req_wdata;
         end
      end
   end

   assign timer_clear = (state_q == ST_SETUP);
   assign timer_run   = (state_q == ST_ACCESS);

   // Capture on the last access cycle of a read, or at once for an empty read.
   assign cap_en = ((state_q == ST_ACCESS) && acc_last && !txn_write_q)
                 || (accept && !any_lane && !req_write);
   assign cap_be = (state_q == ST_IDLE) ? req_be : txn_be_q;
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_lane_pkg::*;
#(
   parameter int unsigned LANES    = 2,
   parameter bit          REG_PINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_state_e       state_q,
   input  seq_state_e       state_d,
   input  logic             write_q,
   input  logic             write_d,
   input  logic [LANES-1:0] be_q,
   input  logic [LANES-1:0] be_d,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe,
   output logic [LANES-1:0] lane_n
);
   typedef struct packed {
      logic             ce_n;
      logic             we_n;
      logic             oe_n;
      logic             dq_oe;
      logic [LANES-1:0] lane_n;
   } pins_t;

   localparam pins_t PINS_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                   dq_oe: 1'b0, lane_n: '1};

   function automatic pins_t decode(input seq_state_e st, input logic wr,
                                    input logic [LANES-1:0] be);
      pins_t p;
      p        = PINS_IDLE;
      p.ce_n   = (st == ST_IDLE);
      p.we_n   = !((st == ST_ACCESS) && wr);
      p.oe_n   = !((st == ST_ACCESS) && !wr);
      p.dq_oe  = (st != ST_IDLE) && wr;
      p.lane_n = (st == ST_IDLE) ? '1 : ~be;
      return p;
   endfunction

   pins_t pins;

   generate
      if (REG_PINS) begin : g_reg
         // Pins come straight from flops, decoded from the next state.
         pins_t pins_q;
         logic  unused_ok;
         assign unused_ok = ^{state_q, write_q, be_q};
         always_ff @(posedge clk) begin
            if (!rst_n) pins_q <= PINS_IDLE;
            else        pins_q <= decode(state_d, write_d, be_d);
         end
         assign pins = pins_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, state_d, write_d, be_d};
         assign pins = decode(state_q, write_q, be_q);
      end
   endgenerate

   assign ce_n   = pins.ce_n;
   assign we_n   = pins.we_n;
   assign oe_n   = pins.oe_n;
   assign dq_oe  = pins.dq_oe;
   assign lane_n = pins.lane_n;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_en,
   input  logic [LANES-1:0]        cap_be,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic                    rsp_valid,
   output logic [LANES*LANE_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap_en;
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rsp_rdata[k*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
               rsp_rdata[k*LANE_W +: LANE_W] <=
                  cap_be[k] ? dq_in[k*LANE_W +: LANE_W] : '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LANES    = 2,
   parameter int unsigned CLK_PS   = 20000,
   parameter int unsigned ACC_PS   = 12000,
   parameter bit          REG_PINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_ce_n,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic [LANES-1:0]  ram_lane_n,
   output logic [DATA_W-1:0] ram_dq_out,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_dq_in
);
   localparam int unsigned LANE_W   = DATA_W / LANES;
   localparam int unsigned WAIT_CYC = access_cycles(CLK_PS, ACC_PS);
   localparam int unsigned CNT_W    = $clog2(WAIT_CYC + 1);

   generate
      if (LANES < 1 || DATA_W % LANES != 0) begin : g_bad_lanes
         $error("DATA_W must split evenly into LANES byte lanes");
      end
      if (ADDR_W < 1 || CLK_PS < 1) begin : g_bad_clk
         $error("ADDR_W and CLK_PS must be nonzero");
      end
      if (WAIT_CYC > 1024) begin : g_bad_wait
         $error("access time too long for the wait counter");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic              txn_write_q, txn_write_d;
   logic [LANES-1:0]  txn_be_q, txn_be_d;
   logic [ADDR_W-1:0] txn_addr_q;
   logic [DATA_W-1:0] txn_wdata_q;
   logic              timer_clear, timer_run, acc_last;
   logic              cap_en;
   logic [LANES-1:0]  cap_be;

   sram_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_be      (req_be),
      .acc_last    (acc_last),
      .req_ready   (req_ready),
      .state_q     (state_q),
      .state_d     (state_d),
      .txn_write_q (txn_write_q),
      .txn_write_d (txn_write_d),
      .txn_be_q    (txn_be_q),
      .txn_be_d    (txn_be_d),
      .txn_addr_q  (txn_addr_q),
      .txn_wdata_q (txn_wdata_q),
      .timer_clear (timer_clear),
      .timer_run   (timer_run),
      .cap_en      (cap_en),
      .cap_be      (cap_be)
   );

   sram_wait_timer #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (timer_clear),
      .run   (timer_run),
      .last  (acc_last)
   );

   sram_pin_drive #(.LANES(LANES), .REG_PINS(REG_PINS)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_q (state_q),
      .state_d (state_d),
      .write_q (txn_write_q),
      .write_d (txn_write_d),
      .be_q    (txn_be_q),
      .be_d    (txn_be_d),
      .ce_n    (ram_ce_n),
      .we_n    (ram_we_n),
      .oe_n    (ram_oe_n),
      .dq_oe   (ram_dq_oe),
      .lane_n  (ram_lane_n)
   );

   sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .cap_be    (cap_be),
      .dq_in     (ram_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign ram_addr   = txn_addr_q;
   assign ram_dq_out = txn_wdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LANES  = 2,
   parameter int unsigned CLK_PS = 20000,
   parameter int unsigned ACC_PS = 12000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              ram_ce_n,
   input logic              ram_we_n,
   input logic              ram_oe_n,
   input logic [LANES-1:0]  ram_lane_n,
   input logic              ram_dq_oe,
   input logic [ADDR_W-1:0] ram_addr
);
   localparam int unsigned WAIT_CYC = access_cycles(CLK_PS, ACC_PS);

   logic        strobe_on;
   logic [15:0] strobe_cnt;
   assign strobe_on = !ram_we_n || !ram_oe_n;

   always_ff @(posedge clk) begin
      if (!rst_n)         strobe_cnt <= '0;
      else if (strobe_on) strobe_cnt <= strobe_cnt + 16'd1;
      else                strobe_cnt <= '0;
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && (&ram_lane_n))); // R1

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_ce_n && $past(!ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_lane_n))); // R2

   AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> ($past(!ram_ce_n) && $stable(ram_addr) && $stable(ram_lane_n))); // R3

   AST_WE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> (!ram_ce_n && ram_dq_oe && $stable(ram_addr))); // R3

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_we_n && !ram_oe_n)); // R5

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !req_ready) |=> !rsp_valid); // R6

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_dq_oe && !ram_oe_n)); // R8

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_oe_n) |-> ($past(!ram_dq_oe) && $past(!ram_ce_n))); // R8

   AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_on && $past(strobe_on)) |-> (strobe_cnt == 16'(WAIT_CYC))); // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .CLK_PS (CLK_PS),
   .ACC_PS (ACC_PS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .ram_ce_n   (ram_ce_n),
   .ram_we_n   (ram_we_n),
   .ram_oe_n   (ram_oe_n),
   .ram_lane_n (ram_lane_n),
   .ram_dq_oe  (ram_dq_oe),
   .ram_addr   (ram_addr)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
   localparam int CLK_PS = 20000;
   localparam int ACC_PS = 45000;  // slower part: three access cycles
   localparam int WQ     = ((ACC_PS + CLK_PS - 1) / CLK_PS < 1) ? 1 : (ACC_PS + CLK_PS - 1) / CLK_PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata, ram_addr, ram_dq_out;
   logic [15:0] ram_dq_in = 16'hC3C3;
   logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [1:0]  ram_lane_n;

   always #10 clk = ~clk;

   sram_lane_ctrl #(.CLK_PS(CLK_PS), .ACC_PS(ACC_PS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_lane_n(ram_lane_n), .ram_dq_out(ram_dq_out),
      .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Shadow memory of the requests and RAM pin model memory.
   logic [15:0] sh_mem  [int];
   logic [15:0] pin_mem [int];
   function automatic logic [15:0] sh_rd(input int a);
      return sh_mem.exists(a) ? sh_mem[a] : 16'h0000;
   endfunction
   function automatic logic [15:0] pin_rd(input int a);
      return pin_mem.exists(a) ? pin_mem[a] : 16'h0000;
   endfunction

   // Behavioural reference: phase counter of the transaction in flight.
   int          ph = 0;
   logic        m_wr;
   logic [15:0] m_addr, m_data;
   logic [1:0]  m_be;
   logic        e_rv = 1'b0;
   logic [15:0] e_rd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; e_rv = 1'b0;
      end else begin
         e_rv = 1'b0;
         if (ph == 0) begin
            if (req_valid) begin
               if (req_be == 2'b00) begin
                  if (!req_write) begin e_rv = 1'b1; e_rd = 16'h0; end
               end else begin
                  m_wr = req_write; m_addr = req_addr; m_data = req_wdata; m_be = req_be;
                  if (req_write) begin
                     logic [15:0] v;
                     v = sh_rd(int'(req_addr));
                     if (req_be[0]) v[7:0]  = req_wdata[7:0];
                     if (req_be[1]) v[15:8] = req_wdata[15:8];
                     sh_mem[int'(req_addr)] = v;
                  end
                  ph = 1;
               end
            end
         end else if (ph == WQ + 1) begin
            if (!m_wr) begin
               logic [15:0] v;
               v = sh_rd(int'(m_addr));
               e_rv = 1'b1;
               e_rd = {m_be[1] ? v[15:8] : 8'h00, m_be[0] ? v[7:0] : 8'h00};
            end
            ph = WQ + 2;
         end else if (ph == WQ + 2) begin
            ph = 0;
         end else begin
            ph = ph + 1;
         end
      end
   end

   // RAM pin model: commit writes, then drive read data (filler on unselected lanes).
   always @(negedge clk) begin
      if (!ram_ce_n && !ram_we_n) begin
         logic [15:0] v;
         v = pin_rd(int'(ram_addr));
         if (!ram_lane_n[0]) v[7:0]  = ram_dq_out[7:0];
         if (!ram_lane_n[1]) v[15:8] = ram_dq_out[15:8];
         pin_mem[int'(ram_addr)] = v;
      end
      if (!ram_ce_n && !ram_oe_n && ram_we_n && !ram_dq_oe) begin
         logic [15:0] v;
         v = pin_rd(int'(ram_addr));
         ram_dq_in = {ram_lane_n[1] ? 8'h5A : v[15:8], ram_lane_n[0] ? 8'hA5 : v[7:0]};
      end else begin
         ram_dq_in = 16'hC3C3;
      end
   end

   // Cycle-by-cycle comparison against the reference.
   logic prev_dq_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit acc, idle;
         idle = (ph == 0);
         acc  = (ph >= 2) && (ph <= WQ + 1);
         chk(req_ready == idle, "R9 ready", req_ready, idle);
         chk(ram_ce_n == idle, idle ? "R1 ce_n" : "R3 ce_n", ram_ce_n, idle);
         chk(ram_we_n == !(acc && m_wr), "R3 R10 we_n", ram_we_n, !(acc && m_wr));
         chk(ram_oe_n == !(acc && !m_wr), "R5 R10 oe_n", ram_oe_n, !(acc && !m_wr));
         chk(ram_dq_oe == (!idle && m_wr), "R4 dq_oe", ram_dq_oe, !idle && m_wr);
         chk(ram_lane_n == (idle ? 2'b11 : ~m_be), idle ? "R1 lane_n" : "R2 lane_n",
             ram_lane_n, idle ? 2'b11 : ~m_be);
         if (!idle) chk(ram_addr == m_addr, "R2 addr", ram_addr, m_addr);
         if (ram_dq_oe) chk(ram_dq_out == m_data, "R4 dq_out", ram_dq_out, m_data);
         chk(rsp_valid == e_rv, "R6 R7 rsp_valid", rsp_valid, e_rv);
         if (e_rv) chk(rsp_rdata == e_rd, "R6 R7 rsp_rdata", rsp_rdata, e_rd);
         if (!ram_oe_n) chk(!prev_dq_oe && !ram_dq_oe, "R8 turnaround",
                            {prev_dq_oe, ram_dq_oe}, 2'b00);
      end
      prev_dq_oe = ram_dq_oe;
   end

   task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   initial begin
      int unsigned seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the pins.
      chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && ram_lane_n == 2'b11,
          "R1 reset pins", {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, ram_lane_n}, 6'b111011);
      chk(req_ready && !rsp_valid, "R1 reset ready", {req_ready, rsp_valid}, 2'b10);

      do_req(1'b1, 16'h0010, 16'hBEEF, 2'b11);
      do_req(1'b0, 16'h0010, 16'h0000, 2'b11);   // write then read: turnaround R8
      do_req(1'b1, 16'h0010, 16'h1234, 2'b01);   // low lane only R2
      do_req(1'b0, 16'h0010, 16'h0000, 2'b10);   // high lane: BE00
      do_req(1'b0, 16'h0010, 16'h0000, 2'b01);   // low lane: 0034
      do_req(1'b1, 16'h0010, 16'hFFFF, 2'b00);   // empty write R7
      do_req(1'b0, 16'h0010, 16'h0000, 2'b11);   // still BE34
      do_req(1'b0, 16'h0010, 16'h0000, 2'b00);   // empty read R7
      do_req(1'b0, 16'h0020, 16'h0000, 2'b00);   // empty read back to back R7
      do_req(1'b1, 16'hFFFF, 16'hA1B2, 2'b10);   // top address
      do_req(1'b1, 16'h0000, 16'h0C0D, 2'b11);   // bottom address
      do_req(1'b0, 16'hFFFF, 16'h0000, 2'b11);
      do_req(1'b0, 16'h0000, 16'h0000, 2'b11);

      seed = 32'h1F2E3D4C;
      for (int i = 0; i < 80; i++) begin
         logic [15:0] a;
         seed = seed * 32'd1103515245 + 32'd12345;
         a = (seed[20:18] == 3'd7) ? 16'hFFFF : {13'h0, seed[20:18]};
         do_req(seed[24], a, seed[31:16] ^ seed[15:0], seed[27:26]);
         if (seed[10]) @(negedge clk);
      end
      repeat (WQ + 6) @(negedge clk);
      finish_run();
   end
endmodule